// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches a set of redundant reference clocks (two by default) and the feedback clock of a clock-multiplying loop. It raises a sticky, active-high failure flag for each reference that stops toggling. All monitored clocks arrive as plain single-bit signals. A faster system clock samples them through multi-stage synchronizers, and the block then finds their edges.

Inactivity is not timed against a fixed number of system cycles. A reference counts as dead once it shows no edge while the feedback clock completes a full period. The feedback clock is itself judged against the rising edges of the 1x output clock. If the feedback clock dies, every reference flag is raised in the same cycle. The flags only report failures. A separate selection controller reads them to pick a clock, and it sends a one-cycle clear pulse to re-arm them.

The block has no mode input. Its flags track failures in the same way whether the downstream automatic switchover is enabled or held off by a manual override.

Top module: `clkmon_top`

## Requirements
- R1: A synchronous active-low reset drives every failure flag to 0 by the first clock edge at which it is sampled low, and the flags read 0 when reset is released.
- R2: A reference that holds one level while the feedback clock shows THRESH_REF (default 2) rising edges gets its flag set. Its flag is not set after only one such rising edge.
- R3: A reference that toggles at least once in every feedback period never gets its flag set.
- R4: A feedback clock that holds one level while the 1x output clock shows THRESH_FB (default 2) rising edges sets all reference flags in the same system-clock cycle. One such rising edge is not enough.
- R5: Once set, a flag stays set while no clear pulse arrives, even after its reference recovers.
- R6: A clear pulse (alarm_clr_i = 1) drives all flags to 0 on the next edge. It wins over any set condition in the same cycle, so the flags stay 0 for as long as it is held.
- R7: A clear also restarts every inactivity count. If the references are still dead after a clear, their flags set again only after a further THRESH_REF feedback rising edges, and not right after the clear.
- R8: A flag is set only for its own reference or for a dead feedback clock. The failure of one reference leaves the other reference's flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample all monitored clocks |
| rst_n_i | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | NUM_REF | Redundant reference clocks, one bit each |
| fb_clk_i | input | 1 | Feedback clock of the multiplying loop |
| out1x_clk_i | input | 1 | 1x output clock, used to time the feedback clock |
| alarm_clr_i | input | 1 | One-cycle clear pulse from the selection controller |
| ref_bad_o | output | NUM_REF | Sticky failure flags, bit k for reference k, 1 = failed |

## Verification
Two kinds of internal fault show at the ports. An inactivity counter that fails to restart on an edge shows up as a flag on a healthy reference, one or two feedback periods later. A counter that does not advance leaves a stuck reference unflagged for good. A flag register that loses its hold drops ref_bad_o on the cycle after it was set. A clear that does not restart the counters shows up as a flag that returns on the cycle after the clear, instead of a full feedback period later. The feedback path is checked by watching both bits change in the same cycle, because a fault there splits them.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   // Which transitions an edge finder reports.
   typedef enum logic {
      EDGE_ANY  = 1'b0,
      EDGE_RISE = 1'b1
   } edge_kind_e;

   // Counter width able to hold 0..limit.
   function automatic int cnt_bits(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkmon_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (!rst_n_i) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= async_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/clkmon_edge.sv
module clkmon_edge
   import clkmon_pkg::*;
#(
   parameter int         WIDTH = 2,
   parameter edge_kind_e KIND  = EDGE_ANY
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] edge_o
);

   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         last_q <= '0;
      end else begin
         last_q <= level_i;
      end
   end

   if (KIND == EDGE_RISE) begin : g_rise
      assign edge_o = level_i & ~last_q;
   end else begin : g_any
      assign edge_o = level_i ^ last_q;
   end

endmodule

// File: rtl/clkmon_idle_cnt.sv
module clkmon_idle_cnt
   import clkmon_pkg::*;
#(
   parameter int THRESH = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clr_i,
   input  logic activity_i,
   input  logic tick_i,
   output logic dead_o
);

   if (THRESH < 1) begin : g_bad_thresh
      $error("clkmon_idle_cnt: THRESH must be at least 1");
   end

   localparam int             CNT_W = cnt_bits(THRESH);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || clr_i) begin
         cnt_q <= '0;
      end else if (activity_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dead_o = (cnt_q == LIMIT);

endmodule

// File: rtl/clkmon_flags.sv
module clkmon_flags #(
   parameter int NUM = 2
) (
   input  logic           clk_i,
   input  logic           rst_n_i,
   input  logic           clr_i,
   input  logic [NUM-1:0] set_i,
   output logic [NUM-1:0] flag_o
);

   logic [NUM-1:0] flag_q;

   for (genvar k = 0; k < NUM; k++) begin : g_flag
      always_ff @(posedge clk_i) begin
         if (!rst_n_i || clr_i) begin
            flag_q[k] <= 1'b0;
         end else if (set_i[k]) begin
            flag_q[k] <= 1'b1;
         end
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
   import clkmon_pkg::*;
#(
   parameter int NUM_REF     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int THRESH_REF  = 2,
   parameter int THRESH_FB   = 2
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [NUM_REF-1:0] ref_clk_i,
   input  logic               fb_clk_i,
   input  logic               out1x_clk_i,
   input  logic               alarm_clr_i,
   output logic [NUM_REF-1:0] ref_bad_o
);

   if (NUM_REF < 1) begin : g_bad_num
      $error("clkmon_top: NUM_REF must be at least 1");
   end

   localparam int IDX_FB  = NUM_REF;
   localparam int IDX_O1X = NUM_REF + 1;
   localparam int N_MON   = NUM_REF + 2;

   logic [N_MON-1:0]   sync_w;
   logic [NUM_REF:0]   any_edge_w;   // refs, then feedback
   logic [1:0]         rise_w;       // [0] feedback, [1] 1x output
   logic [NUM_REF-1:0] ref_dead_w;
   logic               fb_dead_w;
   logic [NUM_REF-1:0] set_w;

   clkmon_sync #(.WIDTH(N_MON), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .async_i ({out1x_clk_i, fb_clk_i, ref_clk_i}),
      .sync_o  (sync_w)
   );

   clkmon_edge #(.WIDTH(NUM_REF + 1), .KIND(EDGE_ANY)) any_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .level_i (sync_w[IDX_FB:0]),
      .edge_o  (any_edge_w)
   );

   clkmon_edge #(.WIDTH(2), .KIND(EDGE_RISE)) rise_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .level_i (sync_w[IDX_O1X:IDX_FB]),
      .edge_o  (rise_w)
   );

   for (genvar k = 0; k < NUM_REF; k++) begin : g_ref
      clkmon_idle_cnt #(.THRESH(THRESH_REF)) cnt_i (
         .clk_i      (clk_i),
         .rst_n_i    (rst_n_i),
         .clr_i      (alarm_clr_i),
         .activity_i (any_edge_w[k]),
         .tick_i     (rise_w[0]),
         .dead_o     (ref_dead_w[k])
      );
   end

   clkmon_idle_cnt #(.THRESH(THRESH_FB)) fb_cnt_i (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .clr_i      (alarm_clr_i),
      .activity_i (any_edge_w[IDX_FB]),
      .tick_i     (rise_w[1]),
      .dead_o     (fb_dead_w)
   );

   assign set_w = ref_dead_w | {NUM_REF{fb_dead_w}};

   clkmon_flags #(.NUM(NUM_REF)) flags_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .clr_i   (alarm_clr_i),
      .set_i   (set_w),
      .flag_o  (ref_bad_o)
   );

endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk #(
   parameter int NUM_REF = 2
) (
   input logic               clk_i,
   input logic               rst_n_i,
   input logic               alarm_clr_i,
   input logic [NUM_REF-1:0] ref_bad_o,
   input logic [NUM_REF-1:0] ref_dead,
   input logic               fb_dead
);

   // R1: flags come out of reset cleared
   assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(rst_n_i) |-> (ref_bad_o == '0));

   // R5: no flag falls without a clear
   assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !alarm_clr_i |=> ((ref_bad_o & $past(ref_bad_o)) == $past(ref_bad_o)));

   // R6: clear wins and empties every flag
   assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      alarm_clr_i |=> (ref_bad_o == '0));

   // R4: dead feedback raises every flag
   assert_fb_all_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (fb_dead && !alarm_clr_i) |=> (&ref_bad_o));

   for (genvar k = 0; k < NUM_REF; k++) begin : g_bit
      // R2: a dead reference raises its own flag
      assert_ref_set_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         (ref_dead[k] && !alarm_clr_i) |=> ref_bad_o[k]);

      // R8: a flag rises only for its own cause or the feedback
      assert_no_stray_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         $rose(ref_bad_o[k]) |-> $past(ref_dead[k] || fb_dead));
   end

endmodule

bind clkmon_top clkmon_chk #(.NUM_REF(NUM_REF)) chk_i (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .alarm_clr_i (alarm_clr_i),
   .ref_bad_o   (ref_bad_o),
   .ref_dead    (ref_dead_w),
   .fb_dead     (fb_dead_w)
);

// File: tb/clkmon_top_tb.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_clk = 2'b00;
   logic       fb_clk = 1'b0;
   logic       o1x_clk = 1'b0;
   logic       clr = 1'b0;
   logic [1:0] bad;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   bit mon_split = 1'b0;
   bit split_seen = 1'b0;

   always #2.5 clk = ~clk;

   clkmon_top dut_i (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .ref_clk_i   (ref_clk),
      .fb_clk_i    (fb_clk),
      .out1x_clk_i (o1x_clk),
      .alarm_clr_i (clr),
      .ref_bad_o   (bad)
   );

   task automatic chk(input string req, input logic [1:0] exp);
      checks++;
      if (bad !== exp) begin
         fails++;
         $display("FAIL %s: ref_bad_o=%b expected %b at %0t", req, bad, exp, $time);
      end
   endtask

   // Advance n system cycles; references toggle every 4 cycles,
   // feedback and 1x output every 8 (feedback rises every 16).
   task automatic run(input int n, input bit ea, input bit eb,
                      input bit ef, input bit eo);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mon_split && (bad == 2'b01 || bad == 2'b10)) split_seen = 1'b1;
         ph++;
         if (ea && ph % 4 == 0) ref_clk[0] = ~ref_clk[0];
         if (eb && ph % 4 == 2) ref_clk[1] = ~ref_clk[1];
         if (ef && ph % 8 == 0) fb_clk = ~fb_clk;
         if (eo && ph % 8 == 4) o1x_clk = ~o1x_clk;
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic t_reset();
      run(4, 0, 0, 0, 0);
      chk("R1 reset state", 2'b00);
      @(negedge clk); rst_n = 1'b1;
      run(2, 0, 0, 0, 0);
      chk("R1 after release", 2'b00);
   endtask

   task automatic t_healthy();
      run(300, 1, 1, 1, 1);
      chk("R3 healthy clocks", 2'b00);
   endtask

   task automatic t_ref_a_stuck();
      run(10, 0, 1, 1, 1);
      chk("R2 not before two feedback edges", 2'b00);
      run(50, 0, 1, 1, 1);
      chk("R2/R8 ref0 flagged alone", 2'b01);
   endtask

   task automatic t_sticky();
      run(120, 1, 1, 1, 1);
      chk("R5 flag held after recovery", 2'b01);
   endtask

   task automatic t_clear();
      pulse_clr();
      chk("R6 clear pulse", 2'b00);
      run(120, 1, 1, 1, 1);
      chk("R6 stays clear while healthy", 2'b00);
   endtask

   task automatic t_clear_held();
      @(negedge clk); clr = 1'b1;
      run(60, 0, 0, 1, 1);
      chk("R6 held clear beats set", 2'b00);
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic t_relatch();
      run(60, 0, 0, 1, 1);
      chk("R2 both refs dead", 2'b11);
      pulse_clr();
      chk("R7 cleared", 2'b00);
      run(10, 0, 0, 1, 1);
      chk("R7 no early relatch", 2'b00);
      run(50, 0, 0, 1, 1);
      chk("R7 relatched after feedback period", 2'b11);
   endtask

   task automatic t_mid_reset();
      @(negedge clk); rst_n = 1'b0;
      run(2, 0, 0, 1, 1);
      chk("R1 reset clears set flags", 2'b00);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_fb_loss();
      run(60, 1, 1, 1, 1);
      chk("R3 healthy before feedback loss", 2'b00);
      mon_split = 1'b1;
      run(10, 1, 1, 0, 1);
      chk("R4 not before two output edges", 2'b00);
      run(50, 1, 1, 0, 1);
      mon_split = 1'b0;
      chk("R4 both flags on feedback loss", 2'b11);
      checks++;
      if (split_seen) begin
         fails++;
         $display("FAIL R4: flags split, actual split=1 expected 0");
      end
   endtask

   initial begin
      t_reset();
      t_healthy();
      t_ref_a_stuck();
      t_sticky();
      t_clear();
      t_clear_held();
      t_relatch();
      t_mid_reset();
      t_fb_loss();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule